// File: doc/BRIEF.md
# Register Rename Table with Ready Scoreboard

This block holds the architectural-to-physical register mapping of an out-of-order core, together with one ready bit per physical register. Architectural indices fall into three regions: integer first, then floating-point, then miscellaneous. Integer and floating-point registers are renamed through a mapping table. Miscellaneous registers are never renamed. Each of them sits at a fixed physical slot above all renameable physical registers.

Each cycle the block accepts at most one rename request. A rename of an ordinary integer or float register pops one index from the matching external free list. It writes that index into the table and marks the new physical register busy. In the same cycle it returns the new and the previous mapping. Besides renaming, the block offers a combinational lookup port, a direct table write used for rollback, a mark-ready write, a combinational ready query, and a free-capacity output. The capacity output is the smaller of the two free-list counts.

The reset synchroniser releases the internal reset two clock edges after `rst_n` rises. Default sizes are 8 integer and 8 float architectural registers, 16 integer and 16 float physical registers, and 4 miscellaneous registers. Integer zero is architectural index 0 and float zero is architectural index 8.

Top module: `rnm_rename_table`

## Requirements
- R1: Architectural index a is integer when a < N_LINT (8). It is float when N_LINT <= a < N_LINT+N_LFP (16). Otherwise it is miscellaneous.
- R2: After reset, integer architectural register i maps to physical i. Physical 0..7 read ready and physical 8..15 read not ready.
- R3: After reset, float architectural register 8+k maps to physical 16+k. Physical 16..23 read ready, physical 24..31 read not ready and physical 32..35 read ready.
- R4: Miscellaneous register a always resolves to physical 32+(a-16) on lookup and on rename. On rename the previous and new outputs are equal and no free list is popped.
- R5: A rename of integer zero (arch 0) or float zero (arch 8) pops nothing and leaves the table unchanged. It returns 0 or 16 respectively as the new mapping, and the current table entry as the previous mapping.
- R6: An accepted rename of any other integer or float register reports the current entry as previous and the matching free-list head as new, with a one-cycle pop. From the next cycle the table holds the new index and that physical register reads not ready.
- R7: An accepted rename of a miscellaneous register makes its fixed physical register read not ready from the next cycle.
- R8: A mark-ready write of physical index p makes p read ready from the next cycle. The ready query returns the bit combinationally.
- R9: A direct write sets the entry of an integer or float architectural index from the next cycle. A miscellaneous index, or an index equal to a same-cycle rename target, is illegal input.
- R10: The capacity output always equals min(int_free_cnt, fp_free_cnt).
- R11: ren_ready is low exactly when the request targets a non-zero integer register while the integer free list is empty, or a non-zero float register while the float free list is empty. A refused request pops nothing and changes no state.
- R12: When a rename clears a ready bit and a mark-ready sets the same bit in the same cycle, the bit reads not ready afterwards.
- R13: The lookup output reflects the current table combinationally in the same cycle as lk_arch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_arch | input | AW (5) | Architectural index to rename |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_new | output | PW (6) | New physical index for the request |
| ren_prev | output | PW (6) | Previous physical index for the request |
| int_fl_valid | input | 1 | Integer free list not empty |
| int_fl_idx | input | PW (6) | Integer free-list head |
| int_fl_pop | output | 1 | Consume integer free-list head |
| fp_fl_valid | input | 1 | Float free list not empty |
| fp_fl_idx | input | PW (6) | Float free-list head |
| fp_fl_pop | output | 1 | Consume float free-list head |
| lk_arch | input | AW (5) | Lookup architectural index |
| lk_phys | output | PW (6) | Lookup result |
| wr_valid | input | 1 | Direct table write |
| wr_arch | input | AW (5) | Direct write architectural index |
| wr_phys | input | PW (6) | Direct write physical index |
| rdy_set_valid | input | 1 | Mark-ready write |
| rdy_set_idx | input | PW (6) | Physical index to mark ready |
| rdy_q_idx | input | PW (6) | Ready query index |
| rdy_q_out | output | 1 | Ready bit of queried register |
| int_free_cnt | input | CW (5) | Integer free-list count |
| fp_free_cnt | input | CW (5) | Float free-list count |
| free_cap | output | CW (5) | Smaller of the two counts |

## Verification
Rename results, pops, handshake, lookups, ready queries and capacity are combinational. They are therefore compared in the same cycle as the stimulus, one nanosecond after inputs change on the falling edge. Table writes, ready clears and ready sets appear one edge later, so the reference model applies them only at the rising edge. The following falling-edge comparison is the first to see them. Stimulus is released only after the two-edge reset synchroniser has let go.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2
  } reg_cls_e;
endpackage

// File: rtl/rnm_decode.sv
module rnm_decode import rnm_pkg::*; #(
  parameter int N_LINT   = 8,
  parameter int N_LFP    = 8,
  parameter int N_PINT   = 16,
  parameter int N_PFP    = 16,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 8,
  parameter int AW       = 5,
  parameter int PW       = 6
) (
  input  logic [AW-1:0] arch,
  output reg_cls_e      cls,
  output logic          is_zero,
  output logic [PW-1:0] zero_phys,
  output logic [PW-1:0] misc_phys
);
  localparam int N_LTOT = N_LINT + N_LFP;
  localparam int N_PTOT = N_PINT + N_PFP;

  always_comb begin
    if (arch < AW'(N_LINT))      cls = CLS_INT;
    else if (arch < AW'(N_LTOT)) cls = CLS_FP;
    else                         cls = CLS_MISC;
  end

  // Zero registers resolve to their reset-time physical slot.
  assign is_zero   = (arch == AW'(INT_ZERO)) || (arch == AW'(FP_ZERO));
  assign zero_phys = (arch == AW'(INT_ZERO)) ? PW'(INT_ZERO)
                                            : PW'(N_PINT + FP_ZERO - N_LINT);
  assign misc_phys = PW'(N_PTOT) + PW'(arch) - PW'(N_LTOT);
endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
  parameter int N_LINT = 8,
  parameter int N_LFP  = 8,
  parameter int N_PINT = 16,
  parameter int AW     = 5,
  parameter int PW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd0_arch,
  output logic [PW-1:0] rd0_phys,
  input  logic [AW-1:0] rd1_arch,
  output logic [PW-1:0] rd1_phys,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_arch,
  input  logic [PW-1:0] wa_phys,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_arch,
  input  logic [PW-1:0] wb_phys
);
  localparam int N_LTOT = N_LINT + N_LFP;
  localparam int TW     = (N_LTOT > 1) ? $clog2(N_LTOT) : 1;

  logic [PW-1:0] map_q [N_LTOT];
  logic [PW-1:0] map_d [N_LTOT];

  assign rd0_phys = (rd0_arch < AW'(N_LTOT)) ? map_q[TW'(rd0_arch)] : '0;
  assign rd1_phys = (rd1_arch < AW'(N_LTOT)) ? map_q[TW'(rd1_arch)] : '0;

  always_comb begin
    for (int i = 0; i < N_LTOT; i++) map_d[i] = map_q[i];
    if (wb_en && wb_arch < AW'(N_LTOT)) map_d[TW'(wb_arch)] = wb_phys;
    if (wa_en && wa_arch < AW'(N_LTOT)) map_d[TW'(wa_arch)] = wa_phys;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LTOT; i++)
        map_q[i] <= (i < N_LINT) ? PW'(i) : PW'(N_PINT + i - N_LINT);
    end else begin
      for (int i = 0; i < N_LTOT; i++) map_q[i] <= map_d[i];
    end
  end

  // A rename write lands in the table on the following edge.
  assert_table_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wa_arch < AW'(N_LTOT)) |=> (map_q[TW'($past(wa_arch))] == $past(wa_phys)));

  // The two write ports must never target one entry together.
  assert_no_write_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_en && wb_en && wa_arch == wb_arch));
endmodule

// File: rtl/rnm_ready_board.sv
module rnm_ready_board #(
  parameter int N_LINT = 8,
  parameter int N_LFP  = 8,
  parameter int N_PINT = 16,
  parameter int N_PFP  = 16,
  parameter int N_MISC = 4,
  parameter int PW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [PW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_idx,
  input  logic [PW-1:0] q_idx,
  output logic          q_rdy
);
  localparam int N_PTOT = N_PINT + N_PFP;
  localparam int N_ALL  = N_PTOT + N_MISC;

  logic [N_ALL-1:0] rdy_q;
  logic [N_ALL-1:0] rdy_d;

  function automatic logic reset_bit(input int i);
    if (i < N_LINT)               return 1'b1;
    else if (i < N_PINT)          return 1'b0;
    else if (i < N_PINT + N_LFP)  return 1'b1;
    else if (i < N_PTOT)          return 1'b0;
    else                          return 1'b1;
  endfunction

  assign q_rdy = (q_idx < PW'(N_ALL)) ? rdy_q[q_idx] : 1'b0;

  // Clear is applied after set so a rename wins a same-index race.
  always_comb begin
    rdy_d = rdy_q;
    if (set_en && set_idx < PW'(N_ALL)) rdy_d[set_idx] = 1'b1;
    if (clr_en && clr_idx < PW'(N_ALL)) rdy_d[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ALL; i++) rdy_q[i] <= reset_bit(i);
    end else begin
      rdy_q <= rdy_d;
    end
  end

  assert_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_en && clr_idx == set_idx && clr_idx < PW'(N_ALL))
      |=> !rdy_q[$past(clr_idx)]);

  assert_set_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_idx < PW'(N_ALL) && !(clr_en && clr_idx == set_idx))
      |=> rdy_q[$past(set_idx)]);
endmodule

// File: rtl/rnm_rename_table.sv
module rnm_rename_table import rnm_pkg::*; #(
  parameter int N_LINT   = 8,
  parameter int N_PINT   = 16,
  parameter int N_LFP    = 8,
  parameter int N_PFP    = 16,
  parameter int N_MISC   = 4,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 8,
  localparam int N_LTOT  = N_LINT + N_LFP,
  localparam int N_PTOT  = N_PINT + N_PFP,
  localparam int AW      = $clog2(N_LTOT + N_MISC),
  localparam int PW      = $clog2(N_PTOT + N_MISC),
  localparam int CW      = $clog2(((N_PINT > N_PFP) ? N_PINT : N_PFP) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  output logic          ren_ready,
  output logic [PW-1:0] ren_new,
  output logic [PW-1:0] ren_prev,
  input  logic          int_fl_valid,
  input  logic [PW-1:0] int_fl_idx,
  output logic          int_fl_pop,
  input  logic          fp_fl_valid,
  input  logic [PW-1:0] fp_fl_idx,
  output logic          fp_fl_pop,
  input  logic [AW-1:0] lk_arch,
  output logic [PW-1:0] lk_phys,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_phys,
  input  logic          rdy_set_valid,
  input  logic [PW-1:0] rdy_set_idx,
  input  logic [PW-1:0] rdy_q_idx,
  output logic          rdy_q_out,
  input  logic [CW-1:0] int_free_cnt,
  input  logic [CW-1:0] fp_free_cnt,
  output logic [CW-1:0] free_cap
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  reg_cls_e      ren_cls, lk_cls;
  logic          ren_zero, lk_zero_unused;
  logic [PW-1:0] ren_zphys, ren_mphys, lk_zphys_unused, lk_mphys;
  logic [PW-1:0] tbl_prev, tbl_lk;
  logic          need_int, need_fp, accept, ren_misc;
  logic          tbl_we, wr_legal, clr_en;
  logic [PW-1:0] alloc_idx, clr_idx;

  rnm_decode #(.N_LINT(N_LINT), .N_LFP(N_LFP), .N_PINT(N_PINT), .N_PFP(N_PFP),
               .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .AW(AW), .PW(PW)) u_dec_ren (
    .arch(ren_arch), .cls(ren_cls), .is_zero(ren_zero),
    .zero_phys(ren_zphys), .misc_phys(ren_mphys));

  rnm_decode #(.N_LINT(N_LINT), .N_LFP(N_LFP), .N_PINT(N_PINT), .N_PFP(N_PFP),
               .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .AW(AW), .PW(PW)) u_dec_lk (
    .arch(lk_arch), .cls(lk_cls), .is_zero(lk_zero_unused),
    .zero_phys(lk_zphys_unused), .misc_phys(lk_mphys));

  // Rename control
  always_comb begin
    need_int   = (ren_cls == CLS_INT) && !ren_zero;
    need_fp    = (ren_cls == CLS_FP)  && !ren_zero;
    ren_misc   = (ren_cls == CLS_MISC);
    ren_ready  = !(need_int && !int_fl_valid) && !(need_fp && !fp_fl_valid);
    accept     = ren_valid && ren_ready;
    int_fl_pop = accept && need_int;
    fp_fl_pop  = accept && need_fp;
    alloc_idx  = need_int ? int_fl_idx : fp_fl_idx;
    tbl_we     = int_fl_pop || fp_fl_pop;
    if (ren_misc)      ren_new = ren_mphys;
    else if (ren_zero) ren_new = ren_zphys;
    else               ren_new = alloc_idx;
    ren_prev   = ren_misc ? ren_mphys : tbl_prev;
    clr_en     = tbl_we || (accept && ren_misc);
    clr_idx    = ren_misc ? ren_mphys : alloc_idx;
    wr_legal   = wr_valid && (wr_arch < AW'(N_LTOT));
    lk_phys    = (lk_cls == CLS_MISC) ? lk_mphys : tbl_lk;
    free_cap   = (int_free_cnt < fp_free_cnt) ? int_free_cnt : fp_free_cnt;
  end

  rnm_map_table #(.N_LINT(N_LINT), .N_LFP(N_LFP), .N_PINT(N_PINT),
                  .AW(AW), .PW(PW)) u_map (
    .clk(clk), .rst_n(rst_i_n),
    .rd0_arch(ren_arch), .rd0_phys(tbl_prev),
    .rd1_arch(lk_arch),  .rd1_phys(tbl_lk),
    .wa_en(tbl_we),   .wa_arch(ren_arch), .wa_phys(alloc_idx),
    .wb_en(wr_legal), .wb_arch(wr_arch),  .wb_phys(wr_phys));

  rnm_ready_board #(.N_LINT(N_LINT), .N_LFP(N_LFP), .N_PINT(N_PINT),
                    .N_PFP(N_PFP), .N_MISC(N_MISC), .PW(PW)) u_rdy (
    .clk(clk), .rst_n(rst_i_n),
    .set_en(rdy_set_valid), .set_idx(rdy_set_idx),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .q_idx(rdy_q_idx), .q_rdy(rdy_q_out));

  assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!int_fl_pop || int_fl_valid) && (!fp_fl_pop || fp_fl_valid));

  assert_stall_no_pop_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ren_ready |-> (!int_fl_pop && !fp_fl_pop));

  assert_misc_passthru_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && ren_arch >= AW'(N_LTOT)) |-> (ren_new == ren_prev && !int_fl_pop && !fp_fl_pop));

  assert_zero_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ren_valid && (ren_arch == AW'(INT_ZERO) || ren_arch == AW'(FP_ZERO)))
      |-> (ren_ready && !int_fl_pop && !fp_fl_pop));

  assert_wr_not_misc_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_valid |-> (wr_arch < AW'(N_LTOT)));

  assert_wr_ren_collide_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(accept && wr_valid && wr_arch == ren_arch));

  assert_cap_min_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (free_cap <= int_free_cnt) && (free_cap <= fp_free_cnt));
endmodule

// File: tb/sim_rnm_rename_table.sv
`timescale 1ns/1ps
module sim_rnm_rename_table;
  localparam int AW = 5, PW = 6, CW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic ren_valid, int_fl_valid, fp_fl_valid, wr_valid, rdy_set_valid;
  logic [AW-1:0] ren_arch, lk_arch, wr_arch;
  logic [PW-1:0] int_fl_idx, fp_fl_idx, wr_phys, rdy_set_idx, rdy_q_idx;
  logic [CW-1:0] int_free_cnt, fp_free_cnt;
  logic ren_ready, int_fl_pop, fp_fl_pop, rdy_q_out;
  logic [PW-1:0] ren_new, ren_prev, lk_phys;
  logic [CW-1:0] free_cap;

  always #2.5 clk = ~clk;

  rnm_rename_table u0 (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_ready(ren_ready),
    .ren_new(ren_new), .ren_prev(ren_prev),
    .int_fl_valid(int_fl_valid), .int_fl_idx(int_fl_idx), .int_fl_pop(int_fl_pop),
    .fp_fl_valid(fp_fl_valid), .fp_fl_idx(fp_fl_idx), .fp_fl_pop(fp_fl_pop),
    .lk_arch(lk_arch), .lk_phys(lk_phys),
    .wr_valid(wr_valid), .wr_arch(wr_arch), .wr_phys(wr_phys),
    .rdy_set_valid(rdy_set_valid), .rdy_set_idx(rdy_set_idx),
    .rdy_q_idx(rdy_q_idx), .rdy_q_out(rdy_q_out),
    .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt), .free_cap(free_cap));

  int checks = 0, failures = 0;
  bit finished = 0;
  int m_map [16];
  bit m_rdy [36];
  string ph = "R2";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int misc_of(input int a); return 32 + a - 16; endfunction

  // Compare combinational results now, then advance the model at the edge.
  task automatic step();
    int a, cls, en, ep, el, fi, ff;
    bit zero, ni, nf, hs, acc;
    #1;
    a = int'(ren_arch);
    cls = (a < 8) ? 0 : (a < 16) ? 1 : 2;
    zero = (a == 0) || (a == 8);
    ni = (cls == 0) && !zero;
    nf = (cls == 1) && !zero;
    hs = !(ni && !int_fl_valid) && !(nf && !fp_fl_valid);
    acc = ren_valid && hs;
    fi = int'(int_fl_idx); ff = int'(fp_fl_idx);
    chk(ren_ready == hs, "R11", ren_ready, hs);
    chk(int_fl_pop == (acc && ni), "R11", int_fl_pop, acc && ni);
    chk(fp_fl_pop == (acc && nf), "R11", fp_fl_pop, acc && nf);
    if (acc) begin
      if (cls == 2) begin en = misc_of(a); ep = en; end
      else if (zero) begin en = (a == 0) ? 0 : 16; ep = m_map[a]; end
      else begin en = ni ? fi : ff; ep = m_map[a]; end
      chk(int'(ren_new) == en, (cls == 2) ? "R4" : zero ? "R5" : "R6", ren_new, en);
      chk(int'(ren_prev) == ep, (cls == 2) ? "R4" : zero ? "R5" : "R6", ren_prev, ep);
    end
    el = (int'(lk_arch) < 16) ? m_map[int'(lk_arch)] : misc_of(int'(lk_arch));
    chk(int'(lk_phys) == el, ph, lk_phys, el);
    chk(rdy_q_out == m_rdy[int'(rdy_q_idx)], ph, rdy_q_out, m_rdy[int'(rdy_q_idx)]);
    chk(free_cap == ((int_free_cnt < fp_free_cnt) ? int_free_cnt : fp_free_cnt),
        "R10", free_cap, (int_free_cnt < fp_free_cnt) ? int_free_cnt : fp_free_cnt);
    @(posedge clk);
    if (rdy_set_valid) m_rdy[int'(rdy_set_idx)] = 1'b1;
    if (wr_valid && int'(wr_arch) < 16) m_map[int'(wr_arch)] = int'(wr_phys);
    if (acc && (ni || nf)) begin
      m_map[a] = ni ? fi : ff;
      m_rdy[ni ? fi : ff] = 1'b0;
    end
    if (acc && cls == 2) m_rdy[misc_of(a)] = 1'b0;
    @(negedge clk);
    if (acc && ni) int_fl_idx = (int_fl_idx == 15) ? PW'(8) : int_fl_idx + 1'b1;
    if (acc && nf) fp_fl_idx = (fp_fl_idx == 31) ? PW'(24) : fp_fl_idx + 1'b1;
  endtask

  task automatic idle();
    ren_valid = 0; wr_valid = 0; rdy_set_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    ren_arch = 0; lk_arch = 0; wr_arch = 0; wr_phys = 0;
    int_fl_valid = 1; fp_fl_valid = 1; int_fl_idx = 8; fp_fl_idx = 24;
    rdy_set_idx = 0; rdy_q_idx = 0; int_free_cnt = 8; fp_free_cnt = 8;
    for (int i = 0; i < 16; i++) m_map[i] = (i < 8) ? i : 16 + i - 8;
    for (int i = 0; i < 36; i++)
      m_rdy[i] = (i < 8) || (i >= 16 && i < 24) || (i >= 32);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // Reset state: R1 region boundaries, R2 integer, R3 float, R4 misc
    for (int i = 0; i < 36; i++) begin
      lk_arch = (i < 20) ? AW'(i) : AW'(0);
      rdy_q_idx = PW'(i);
      ph = (i == 7 || i == 8 || i == 15 || i == 16) ? "R1" :
           (i < 8) ? "R2" : (i < 16 || i >= 24) ? "R3" : "R3";
      if (i >= 16 && i < 20) ph = "R4";
      step();
    end

    // R6: integer and float renames, then R13 lookup and ready clear
    ph = "R6";
    ren_valid = 1; ren_arch = 3; step();
    ren_arch = 10; step();
    idle(); lk_arch = 3; rdy_q_idx = 8; step();
    lk_arch = 10; rdy_q_idx = 24; step();
    ph = "R13"; lk_arch = 10; step();

    // R5: zero registers
    ph = "R5";
    ren_valid = 1; ren_arch = 0; lk_arch = 0; step();
    ren_arch = 8; lk_arch = 8; step();
    idle(); step();

    // R7 misc rename clears ready, R8 mark-ready sets it
    ph = "R7";
    ren_valid = 1; ren_arch = 17; rdy_q_idx = 33; lk_arch = 17; step();
    idle(); step();
    ph = "R8";
    rdy_set_valid = 1; rdy_set_idx = 33; step();
    idle(); step();
    rdy_set_valid = 1; rdy_set_idx = 8; rdy_q_idx = 8; step();
    idle(); step();

    // R12: rename clear and mark-ready on the same physical index
    ph = "R12";
    ren_valid = 1; ren_arch = 4; rdy_set_valid = 1; rdy_set_idx = int_fl_idx;
    rdy_q_idx = int_fl_idx; step();
    idle(); step();

    // R11: empty free lists stall only the matching class
    ph = "R11";
    int_fl_valid = 0; ren_valid = 1; ren_arch = 5; lk_arch = 5; step();
    ren_arch = 11; lk_arch = 11; step();
    ren_arch = 0; step();
    fp_fl_valid = 0; ren_arch = 12; lk_arch = 12; step();
    ren_arch = 18; step();
    int_fl_valid = 1; fp_fl_valid = 1; idle(); lk_arch = 5; step();

    // R9: direct write for rollback
    ph = "R9";
    wr_valid = 1; wr_arch = 5; wr_phys = 14; lk_arch = 5; step();
    wr_arch = 13; wr_phys = 29; step();
    idle(); lk_arch = 13; step();

    // R10: capacity under several count pairs
    int_free_cnt = 3; fp_free_cnt = 7; step();
    int_free_cnt = 9; fp_free_cnt = 2; step();
    int_free_cnt = 4; fp_free_cnt = 4; step();
    int_free_cnt = 16; fp_free_cnt = 0; step();

    // Mixed traffic, R6 tag for table and ready tracking
    ph = "R6";
    for (int n = 0; n < 600; n++) begin
      ren_valid = ($urandom_range(0, 3) != 0);
      ren_arch = AW'($urandom_range(0, 19));
      int_fl_valid = ($urandom_range(0, 4) != 0);
      fp_fl_valid = ($urandom_range(0, 4) != 0);
      wr_valid = ($urandom_range(0, 4) == 0);
      wr_arch = AW'($urandom_range(0, 15));
      if (ren_valid && wr_arch == ren_arch) wr_valid = 0;
      wr_phys = PW'((wr_arch < 8) ? $urandom_range(0, 15) : $urandom_range(16, 31));
      rdy_set_valid = ($urandom_range(0, 2) == 0);
      rdy_set_idx = PW'($urandom_range(0, 35));
      rdy_q_idx = PW'($urandom_range(0, 35));
      lk_arch = AW'($urandom_range(0, 19));
      int_free_cnt = CW'($urandom_range(0, 16));
      fp_free_cnt = CW'($urandom_range(0, 16));
      step();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule